// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a clocked host and an asynchronous static RAM organised as 256K words of one bit. The host offers one access at a time: an 18-bit address, a write flag and one bit of write data, with a valid/ready handshake. The sequencer converts each accepted request into the strobe sequence the memory needs. It drives an active-low select, an active-low write strobe, the address bus and the data-in line, and for reads it samples the memory's data-out line.

Every timing minimum of the memory is met by counting system-clock cycles. Each phase length is the nanosecond minimum divided by the clock period, rounded up, with a floor of one cycle. All of these minimums are parameters, so one netlist serves the faster and slower speed grades. Reads finish with a one-cycle valid pulse that carries the sampled bit. Writes return no response. Between accesses the memory is deselected.

Top module: `sram_seq`

## Requirements
- R1: While reset is held, and right after it is released, `mem_cs_n` and `mem_we_n` are high, `req_ready` is high and `rsp_valid` is low.
- R2: `req_ready` is high only when no access is in progress. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. A request presented while `req_ready` is low stays pending until it is taken, and it is never lost.
- R3: `mem_we_n` is low only while `mem_cs_n` is low.
- R4: `mem_we_n` never falls on the same edge as `mem_cs_n`. Select is always low for at least one cycle before the write strobe falls.
- R5: `mem_addr` holds its value for the whole time select is low, including the recovery phase after the write strobe rises.
- R6: `mem_din` holds the request's write data from the cycle before `mem_we_n` falls until after it rises.
- R7: The write strobe stays low for WP = max(ceil(T_WP_NS/CLK_NS), ceil(T_DW_NS/CLK_NS)) cycles. Select then stays low for WR = ceil(T_WR_NS/CLK_NS) more cycles. For a write taken at edge e, `req_ready` is high again after edge e+1+WP+WR.
- R8: A read holds select low with the write strobe high for RD = ceil(T_AA_NS/CLK_NS) cycles. It samples `mem_dout` at the edge that ends that window and presents the bit on `rsp_data` with `rsp_valid` high for exactly one cycle.
- R9: A write never raises `rsp_valid`.
- R10: While idle, `mem_cs_n` is high.
- R11: For a read taken at edge e, `rsp_valid` is high in the cycle after edge e+RD, and `req_ready` is high again in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host offers a request |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 1 | Bit to write |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_data | output | 1 | Bit read |
| mem_addr | output | 18 | Memory address bus |
| mem_din | output | 1 | Memory data input |
| mem_cs_n | output | 1 | Memory select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_dout | input | 1 | Memory data output |

## Verification
For a read taken at edge e, the response is due in the cycle after edge e+RD. The driver pushes that cycle number into the scoreboard along with the expected bit. The monitor samples on falling edges and compares both the cycle and the data.

For a write, the driver records the edge on which the request was taken. It then checks that `req_ready` comes back exactly 1+WP+WR cycles later.

The bench's memory model checks the analog-side rules in nanoseconds:
- It returns X unless the access time has elapsed.
- It checks the strobe width and the data setup time.
- It checks that select fell earlier than the write strobe.
- It checks that the address is held through the recovery phase.

// File: rtl/sram_seq.sv
module sram_seq #(
  parameter int AW      = 18,
  parameter int CLK_NS  = 10,
  parameter int T_AA_NS = 25,
  parameter int T_WP_NS = 20,
  parameter int T_DW_NS = 15,
  parameter int T_WR_NS = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic          req_wdata,
  output logic          rsp_valid,
  output logic          rsp_data,
  output logic [AW-1:0] mem_addr,
  output logic          mem_din,
  output logic          mem_cs_n,
  output logic          mem_we_n,
  input  logic          mem_dout
);
  localparam int RD_RAW = (T_AA_NS + CLK_NS - 1) / CLK_NS;
  localparam int WP_RAW = (T_WP_NS + CLK_NS - 1) / CLK_NS;
  localparam int DW_RAW = (T_DW_NS + CLK_NS - 1) / CLK_NS;
  localparam int WR_RAW = (T_WR_NS + CLK_NS - 1) / CLK_NS;
  localparam int RD_C   = RD_RAW < 1 ? 1 : RD_RAW;
  localparam int WPD    = WP_RAW > DW_RAW ? WP_RAW : DW_RAW;
  localparam int WP_C   = WPD < 1 ? 1 : WPD;
  localparam int WR_C   = WR_RAW < 1 ? 1 : WR_RAW;
  localparam int MAXA   = RD_C > WP_C ? RD_C : WP_C;
  localparam int MAXC   = MAXA > WR_C ? MAXA : WR_C;
  localparam int CW     = $clog2(MAXC + 1);

  typedef enum logic [2:0] {S_IDLE, S_READ, S_WSET, S_WPUL, S_WREC} st_t;

  st_t           st;
  logic [CW-1:0] cnt;

  assign req_ready = (st == S_IDLE);
  assign mem_cs_n  = (st == S_IDLE);
  assign mem_we_n  = (st != S_WPUL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      mem_addr  <= '0;
      mem_din   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_data  <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          mem_addr <= req_addr;
          if (req_write) begin
            mem_din <= req_wdata;
            st      <= S_WSET;
          end else begin
            cnt <= CW'(RD_C - 1);
            st  <= S_READ;
          end
        end
        S_READ: if (cnt == '0) begin
          rsp_data  <= mem_dout;
          rsp_valid <= 1'b1;
          st        <= S_IDLE;
        end else cnt <= cnt - 1'b1;
        S_WSET: begin
          cnt <= CW'(WP_C - 1);
          st  <= S_WPUL;
        end
        S_WPUL: if (cnt == '0) begin
          cnt <= CW'(WR_C - 1);
          st  <= S_WREC;
        end else cnt <= cnt - 1'b1;
        S_WREC: if (cnt == '0) st <= S_IDLE;
                else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  p_strobe_in_select_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_cs_n);

  p_select_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> !$past(mem_cs_n));

  p_addr_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && !$past(mem_cs_n)) |-> $stable(mem_addr));

  p_din_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n || $rose(mem_we_n)) |-> $stable(mem_din));

  p_rsp_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_rsp_after_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(mem_we_n) && !$past(mem_cs_n)));

  p_idle_deselect_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && mem_we_n));
endmodule

// File: tb/sim_sram_seq.sv
`timescale 1ns/1ps
module sim_sram_seq;
  localparam int CLK_NS = 4;
  localparam int T_AA = 25, T_WP = 20, T_DW = 15, T_WR = 3;
  localparam int RD = (T_AA + CLK_NS - 1) / CLK_NS;
  localparam int WPa = (T_WP + CLK_NS - 1) / CLK_NS;
  localparam int DWa = (T_DW + CLK_NS - 1) / CLK_NS;
  localparam int WP = WPa > DWa ? WPa : DWa;
  localparam int WR = (T_WR + CLK_NS - 1) / CLK_NS < 1 ? 1 : (T_WR + CLK_NS - 1) / CLK_NS;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_wdata = 0;
  logic [17:0] req_addr = '0;
  logic req_ready, rsp_valid, rsp_data, mem_din, mem_cs_n, mem_we_n, mem_dout;
  logic [17:0] mem_addr;

  always #2 clk = ~clk;

  sram_seq #(.CLK_NS(CLK_NS), .T_AA_NS(T_AA), .T_WP_NS(T_WP), .T_DW_NS(T_DW), .T_WR_NS(T_WR)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mem_addr(mem_addr),
    .mem_din(mem_din), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_dout(mem_dout));

  int checks = 0, errors = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // memory model
  bit marr [int];
  logic dout_r = 1'bz;
  int gen = 0;
  realtime t_cs = 0, t_ws = 0, t_we = -100, t_din = 0;
  bit in_ov = 0;
  wire ov_n = mem_cs_n | mem_we_n;
  assign mem_dout = dout_r;

  always @(mem_addr or mem_cs_n or mem_we_n) begin
    gen = gen + 1;
    if (mem_cs_n !== 1'b0 || mem_we_n !== 1'b1) dout_r = 1'bz;
    else begin
      dout_r = 1'bx;
      fork
        begin
          automatic int g = gen;
          #(T_AA);
          if (g == gen) dout_r = marr.exists(int'(mem_addr)) ? marr[int'(mem_addr)] : 1'b0;
        end
      join_none
    end
  end
  always @(negedge mem_cs_n) t_cs = $realtime;
  always @(mem_din) t_din = $realtime;
  always @(negedge mem_we_n) if (rst_n)
    chk(mem_cs_n === 1'b0 && $realtime > t_cs, "R4 select before strobe", int'(mem_cs_n), 0);
  always @(negedge ov_n) begin in_ov = 1; t_ws = $realtime; end
  always @(posedge ov_n) if (in_ov) begin
    in_ov = 0;
    t_we = $realtime;
    chk($realtime - t_ws >= T_WP, "R7 strobe width ns", int'($realtime - t_ws), T_WP);
    chk($realtime - t_din >= T_DW, "R6 data setup ns", int'($realtime - t_din), T_DW);
    marr[int'(mem_addr)] = mem_din;
  end
  always @(mem_addr) if (rst_n) begin
    if (in_ov || $realtime - t_we < T_WR)
      chk(0, "R5 address moved in write/recovery", int'($realtime - t_we), T_WR);
  end

  // scoreboard
  typedef struct { bit d; int due; } exp_t;
  exp_t q[$];
  bit shadow [int];
  int nread = 0, nrsp = 0;

  always @(negedge clk) if (rst_n && rsp_valid) begin
    nrsp++;
    if (q.size() == 0) chk(0, "R9 response without read", 1, 0);
    else begin
      automatic exp_t e = q.pop_front();
      chk(rsp_data === e.d, "R8 read data", int'(rsp_data), int'(e.d));
      chk(cyc == e.due, "R11 read latency", cyc, e.due);
      chk(req_ready === 1'b1, "R11 ready with response", int'(req_ready), 1);
    end
  end

  task automatic issue(bit w, logic [17:0] a, bit d);
    int acc;
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    chk(mem_cs_n === 1'b1, "R10 idle deselect", int'(mem_cs_n), 1);
    acc = cyc + 1;
    if (!w) begin
      nread++;
      q.push_back('{shadow.exists(int'(a)) ? shadow[int'(a)] : 1'b0, acc + RD});
    end else shadow[int'(a)] = d;
    @(negedge clk);
    req_valid = 0;
    chk(req_ready === 1'b0, "R2 busy after accept", int'(req_ready), 0);
    if (w) begin
      while (!req_ready) @(negedge clk);
      chk(cyc == acc + 1 + WP + WR, "R7 write cycle length", cyc, acc + 1 + WP + WR);
    end
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        chk(mem_cs_n === 1 && mem_we_n === 1 && rsp_valid === 0, "R1 reset outputs", int'(mem_cs_n & mem_we_n), 1);
        @(negedge clk) rst_n = 1;
        @(negedge clk);
        chk(req_ready === 1 && mem_cs_n === 1 && mem_we_n === 1, "R1 after reset", int'(req_ready), 1);
        issue(0, 18'd5, 0);
        issue(1, 18'd0, 1);
        issue(1, 18'h3FFFF, 1);
        issue(1, 18'd5, 1);
        issue(0, 18'd0, 0);
        issue(0, 18'h3FFFF, 0);
        issue(0, 18'd5, 0);
        issue(0, 18'd5, 0);
        issue(1, 18'd5, 0);
        issue(0, 18'd5, 0);
        for (int i = 0; i < 16; i++) issue(1, 18'(i * 4099), bit'(i % 3 == 0));
        for (int i = 0; i < 16; i++) issue(0, 18'(i * 4099), 0);
        issue(1, 18'h2AAAA, 1);
        issue(0, 18'h2AAAA, 0);
        issue(0, 18'h15555, 0);
        repeat (RD + 4) @(negedge clk);
        chk(q.size() == 0 && nrsp == nread, "R8 all reads answered", nrsp, nread);
        chk(mem_cs_n === 1'b1, "R10 idle at end", int'(mem_cs_n), 1);
      end
      begin
        repeat (100000) @(posedge clk);
        chk(0, "watchdog", cyc, 0);
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule